// File: doc/BRIEF.md
# Scatter-Gather Transmit Descriptor Engine

This block is the transmit half of a scatter-gather DMA channel. Once kicked with a head pointer and a tail pointer while the channel is enabled, it walks a chain of descriptors in memory through a simple word read/write port with a request/acknowledge handshake. For each descriptor it reads the next pointer, the buffer address, the control word and the status word. If the descriptor is already marked complete, it stops with a halt indication. Otherwise it sends the descriptor's five application words on a side-band control stream, but only when start-of-frame is flagged. It then streams the buffer out as 32-bit beats on a data stream and writes the status word back with the complete flag set.

After writeback the current pointer takes the value of the next pointer. The walk ends with an idle indication if the descriptor just finished was the tail. Control and status registers and interrupt generation live outside this block. The engine reports stops, frame completions and its current pointer as plain outputs. Both streams follow the AXI4-Stream valid/ready rules. Buffers are word aligned, and lengths are counted in bytes.

Descriptor layout (byte offsets from the descriptor address, all little-endian 32-bit words):

| Offset | Content |
|---|---|
| 0x00 | next pointer, low word (high word at 0x04 is not read) |
| 0x08 | buffer address, low word (high word at 0x0C is not read) |
| 0x18 | control word |
| 0x1C | status word |
| 0x20 to 0x30 | five application words |

Top module: `sg_tx_engine`

## Requirements
- R1: After synchronous reset, `busy`, `mem_req`, `m_tvalid`, `c_tvalid`, `stop_idle`, `stop_halt` and `frame_done` are all 0.
- R2: A `kick` while `run_en` is 0 is ignored: `busy` stays 0, no memory request is made, and no beat appears on either stream.
- R3: The control word at offset 0x18 supplies the byte length in bits 22:0, end-of-frame in bit 26 and start-of-frame in bit 27. Its other bits are ignored. While `mem_req` is high and unacknowledged, `mem_addr` and `mem_we` hold steady.
- R4: A descriptor whose status word (offset 0x1C) has bit 31 set produces a one-cycle `stop_halt` and no stream beats. Its status word is not written, and `cur_ptr` stays at that descriptor's address.
- R5: When start-of-frame is set, the five application words (offsets 0x20, 0x24, 0x28, 0x2C, 0x30, in that order) go out on the control stream with `c_tlast` on the fifth. All five are accepted before the first data beat of that descriptor.
- R6: A descriptor of length L produces ceil(L/4) data beats carrying consecutive buffer words, starting at the buffer address.
- R7: Every data beat has `m_tkeep` = 4'b1111 except the last beat of a descriptor. That beat has 4'b0001, 4'b0011 or 4'b0111 when L mod 4 is 1, 2 or 3, and 4'b1111 when L mod 4 is 0.
- R8: `m_tlast` is 1 only on the last data beat of a descriptor whose end-of-frame bit is set.
- R9: On either stream, a beat held with valid high and ready low keeps valid high and its payload unchanged in the next cycle.
- R10: Each processed descriptor has 32'h8000_0000 written to its status word. One `frame_done` pulse follows that write exactly when end-of-frame was set.
- R11: After writeback, `cur_ptr` takes the descriptor's next pointer. If the descriptor was the tail, a one-cycle `stop_idle` is issued and `busy` falls. Otherwise the next descriptor is fetched.
- R12: A descriptor of length 0 produces no data beat, but is still written back and still counts toward `frame_done` when end-of-frame is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Channel enable; kicks are accepted only while high |
| kick | input | 1 | Start pulse, used when the engine is not busy |
| head_ptr | input | ADDR_W | First descriptor address, taken on kick |
| tail_ptr | input | ADDR_W | Tail descriptor address, taken on kick |
| busy | output | 1 | Engine is walking the chain |
| cur_ptr | output | ADDR_W | Current descriptor pointer |
| stop_idle | output | 1 | One-cycle pulse: stopped after the tail |
| stop_halt | output | 1 | One-cycle pulse: stopped on a completed descriptor |
| frame_done | output | 1 | One-cycle pulse after writeback of an end-of-frame descriptor |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | ADDR_W | Byte address of the word accessed |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access completes in this cycle |
| m_tdata | output | 32 | Data stream payload |
| m_tkeep | output | 4 | Data stream byte enables |
| m_tlast | output | 1 | Data stream end of frame |
| m_tvalid | output | 1 | Data stream valid |
| m_tready | input | 1 | Data stream ready |
| c_tdata | output | 32 | Control stream application word |
| c_tlast | output | 1 | Control stream marks the fifth word |
| c_tvalid | output | 1 | Control stream valid |
| c_tready | input | 1 | Control stream ready |

## Verification
A wrong walk state is visible at the memory port within one access. A mis-sliced control word or a bad offset sends out the wrong word, beat count or keep on the data stream for the descriptor being processed. A lost or repeated beat under backpressure breaks the payload sequence at the very next accepted beat, and misplaced application words appear before the data that should follow them. A wrong pointer update or stop decision shows up when the walk ends: in the stop pulse kind, in `cur_ptr`, and in which status words in memory were rewritten.

// File: rtl/sg_tx_pkg.sv
package sg_tx_pkg;

    localparam int WORD_W    = 32;
    localparam int KEEP_W    = WORD_W / 8;
    localparam int LEN_W     = 23;
    localparam int APP_WORDS = 5;
    localparam int APP_IW    = $clog2(APP_WORDS);

    // Byte offsets inside a descriptor (low words only).
    localparam logic [7:0] OFF_NEXT = 8'h00;
    localparam logic [7:0] OFF_BUF  = 8'h08;
    localparam logic [7:0] OFF_CTRL = 8'h18;
    localparam logic [7:0] OFF_STAT = 8'h1C;
    localparam logic [7:0] OFF_APP  = 8'h20;

    // Control and status bit positions.
    localparam int BIT_EOF  = 26;
    localparam int BIT_SOF  = 27;
    localparam int BIT_DONE = 31;

    localparam logic [WORD_W-1:0] STATUS_DONE = 32'h8000_0000;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_NEXT,
        ST_RD_BUF,
        ST_RD_CTRL,
        ST_RD_STAT,
        ST_RD_APP,
        ST_PUSH_APP,
        ST_APP_DRAIN,
        ST_DATA_CHK,
        ST_RD_DATA,
        ST_PUSH_DATA,
        ST_WR_STAT
    } walk_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] nxt;
        logic [WORD_W-1:0] buf_addr;
        logic [LEN_W-1:0]  len;
        logic              sof;
        logic              eof;
    } desc_t;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic [KEEP_W-1:0] keep;
        logic              last;
    } dbeat_t;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              last;
    } cbeat_t;

    // Byte enables for the final beat given the low two length bits.
    function automatic logic [KEEP_W-1:0] tail_keep(input logic [1:0] rem_lo);
        case (rem_lo)
            2'd1:    return 4'b0001;
            2'd2:    return 4'b0011;
            2'd3:    return 4'b0111;
            default: return 4'b1111;
        endcase
    endfunction

endpackage

// File: rtl/sg_tx_len_track.sv
module sg_tx_len_track
    import sg_tx_pkg::*;
#(
    parameter int LW = LEN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [LW-1:0]     len_in,
    input  logic              step,
    output logic              has_beat,
    output logic              last_beat,
    output logic [KEEP_W-1:0] keep
);

    localparam logic [LW-1:0] BEAT_BYTES = LW'(KEEP_W);

    logic [LW-1:0] rem;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem <= '0;
        end else if (load) begin
            rem <= len_in;
        end else if (step) begin
            rem <= (rem > BEAT_BYTES) ? rem - BEAT_BYTES : '0;
        end
    end

    assign has_beat  = (rem != '0);
    assign last_beat = (rem <= BEAT_BYTES);
    assign keep      = last_beat ? tail_keep(rem[1:0]) : {KEEP_W{1'b1}};

    // A beat may only be consumed while bytes remain.
    assert_step_has_bytes_R6: assert property (@(posedge clk) disable iff (rst)
        step |-> has_beat);

endmodule

// File: rtl/sg_tx_slot.sv
module sg_tx_slot #(
    parameter int W = 33
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic         can_load,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    input  logic         out_ready
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= din;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    assign can_load = !out_valid || out_ready;

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_no_overwrite_R9: assert property (@(posedge clk) disable iff (rst)
        load |-> can_load);

endmodule

// File: rtl/sg_tx_engine.sv
module sg_tx_engine
    import sg_tx_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic              kick,
    input  logic [ADDR_W-1:0] head_ptr,
    input  logic [ADDR_W-1:0] tail_ptr,
    output logic              busy,
    output logic [ADDR_W-1:0] cur_ptr,
    output logic              stop_idle,
    output logic              stop_halt,
    output logic              frame_done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ack,
    output logic [31:0]       m_tdata,
    output logic [3:0]        m_tkeep,
    output logic              m_tlast,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic [31:0]       c_tdata,
    output logic              c_tlast,
    output logic              c_tvalid,
    input  logic              c_tready
);

    localparam int WIDX_W = LEN_W - 2;
    localparam logic [APP_IW-1:0] APP_LAST = APP_IW'(APP_WORDS - 1);

    walk_state_e       st;
    logic [ADDR_W-1:0] cur;
    logic [ADDR_W-1:0] tail;
    desc_t             d;
    logic [WORD_W-1:0] hold;
    logic [APP_IW-1:0] app_idx;
    logic [WIDX_W-1:0] word_idx;

    logic              trk_load;
    logic              has_beat;
    logic              last_beat;
    logic [KEEP_W-1:0] beat_keep;

    logic              dat_can, dat_load;
    logic              ctl_can, ctl_load;
    dbeat_t            dat_in, dat_out;
    cbeat_t            ctl_in, ctl_out;

    // ---------------- memory port ----------------
    always_comb begin
        mem_addr = cur;
        case (st)
            ST_RD_NEXT: mem_addr = cur + ADDR_W'(OFF_NEXT);
            ST_RD_BUF:  mem_addr = cur + ADDR_W'(OFF_BUF);
            ST_RD_CTRL: mem_addr = cur + ADDR_W'(OFF_CTRL);
            ST_RD_STAT,
            ST_WR_STAT: mem_addr = cur + ADDR_W'(OFF_STAT);
            ST_RD_APP:  mem_addr = cur + ADDR_W'(OFF_APP) + ADDR_W'({app_idx, 2'b00});
            ST_RD_DATA: mem_addr = d.buf_addr[ADDR_W-1:0] + ADDR_W'({word_idx, 2'b00});
            default:    mem_addr = cur;
        endcase
    end

    assign mem_req   = (st == ST_RD_NEXT) || (st == ST_RD_BUF) || (st == ST_RD_CTRL) ||
                       (st == ST_RD_STAT) || (st == ST_RD_APP) || (st == ST_RD_DATA) ||
                       (st == ST_WR_STAT);
    assign mem_we    = (st == ST_WR_STAT);
    assign mem_wdata = STATUS_DONE;

    assign busy    = (st != ST_IDLE);
    assign cur_ptr = cur;

    // ---------------- byte length tracking ----------------
    assign trk_load = (st == ST_RD_STAT) && mem_ack;

    sg_tx_len_track #(.LW(LEN_W)) u_len (
        .clk       (clk),
        .rst       (rst),
        .load      (trk_load),
        .len_in    (d.len),
        .step      (dat_load),
        .has_beat  (has_beat),
        .last_beat (last_beat),
        .keep      (beat_keep)
    );

    // ---------------- output stream slots ----------------
    assign dat_load = (st == ST_PUSH_DATA) && dat_can;
    assign ctl_load = (st == ST_PUSH_APP) && ctl_can;

    always_comb begin
        dat_in.data = hold;
        dat_in.keep = beat_keep;
        dat_in.last = last_beat && d.eof;
        ctl_in.data = hold;
        ctl_in.last = (app_idx == APP_LAST);
    end

    sg_tx_slot #(.W($bits(dbeat_t))) u_dat_slot (
        .clk       (clk),
        .rst       (rst),
        .load      (dat_load),
        .din       (dat_in),
        .can_load  (dat_can),
        .out_valid (m_tvalid),
        .out_data  (dat_out),
        .out_ready (m_tready)
    );

    sg_tx_slot #(.W($bits(cbeat_t))) u_ctl_slot (
        .clk       (clk),
        .rst       (rst),
        .load      (ctl_load),
        .din       (ctl_in),
        .can_load  (ctl_can),
        .out_valid (c_tvalid),
        .out_data  (ctl_out),
        .out_ready (c_tready)
    );

    assign m_tdata = dat_out.data;
    assign m_tkeep = dat_out.keep;
    assign m_tlast = dat_out.last;
    assign c_tdata = ctl_out.data;
    assign c_tlast = ctl_out.last;

    // ---------------- descriptor walk ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            cur        <= '0;
            tail       <= '0;
            d          <= '0;
            hold       <= '0;
            app_idx    <= '0;
            word_idx   <= '0;
            stop_idle  <= 1'b0;
            stop_halt  <= 1'b0;
            frame_done <= 1'b0;
        end else begin
            stop_idle  <= 1'b0;
            stop_halt  <= 1'b0;
            frame_done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (kick && run_en) begin
                        cur  <= head_ptr;
                        tail <= tail_ptr;
                        st   <= ST_RD_NEXT;
                    end
                end
                ST_RD_NEXT: begin
                    if (mem_ack) begin
                        d.nxt <= mem_rdata;
                        st    <= ST_RD_BUF;
                    end
                end
                ST_RD_BUF: begin
                    if (mem_ack) begin
                        d.buf_addr <= mem_rdata;
                        st         <= ST_RD_CTRL;
                    end
                end
                ST_RD_CTRL: begin
                    if (mem_ack) begin
                        d.len <= mem_rdata[LEN_W-1:0];
                        d.eof <= mem_rdata[BIT_EOF];
                        d.sof <= mem_rdata[BIT_SOF];
                        st    <= ST_RD_STAT;
                    end
                end
                ST_RD_STAT: begin
                    if (mem_ack) begin
                        word_idx <= '0;
                        app_idx  <= '0;
                        if (mem_rdata[BIT_DONE]) begin
                            stop_halt <= 1'b1;
                            st        <= ST_IDLE;
                        end else if (d.sof) begin
                            st <= ST_RD_APP;
                        end else begin
                            st <= ST_DATA_CHK;
                        end
                    end
                end
                ST_RD_APP: begin
                    if (mem_ack) begin
                        hold <= mem_rdata;
                        st   <= ST_PUSH_APP;
                    end
                end
                ST_PUSH_APP: begin
                    if (ctl_can) begin
                        if (app_idx == APP_LAST) begin
                            st <= ST_APP_DRAIN;
                        end else begin
                            app_idx <= app_idx + 1'b1;
                            st      <= ST_RD_APP;
                        end
                    end
                end
                ST_APP_DRAIN: begin
                    if (!c_tvalid) st <= ST_DATA_CHK;
                end
                ST_DATA_CHK: begin
                    st <= has_beat ? ST_RD_DATA : ST_WR_STAT;
                end
                ST_RD_DATA: begin
                    if (mem_ack) begin
                        hold <= mem_rdata;
                        st   <= ST_PUSH_DATA;
                    end
                end
                ST_PUSH_DATA: begin
                    if (dat_can) begin
                        word_idx <= word_idx + 1'b1;
                        st       <= ST_DATA_CHK;
                    end
                end
                ST_WR_STAT: begin
                    if (mem_ack) begin
                        frame_done <= d.eof;
                        cur        <= d.nxt[ADDR_W-1:0];
                        if (cur == tail) begin
                            stop_idle <= 1'b1;
                            st        <= ST_IDLE;
                        end else begin
                            st <= ST_RD_NEXT;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // ---------------- assertions ----------------
    assert_req_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_frame_after_wb_R10: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> $past(mem_req && mem_we && mem_ack));

    assert_stop_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
        (stop_idle || stop_halt) |-> (!busy && !(stop_idle && stop_halt)));

    assert_keep_low_byte_R7: assert property (@(posedge clk) disable iff (rst)
        m_tvalid |-> m_tkeep[0]);

    assert_app_drained_R5: assert property (@(posedge clk) disable iff (rst)
        dat_load |-> !c_tvalid);

endmodule

// File: tb/test_sg_tx_engine.sv
module test_sg_tx_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_en = 1'b0;
    logic        kick = 1'b0;
    logic [31:0] head_ptr = '0;
    logic [31:0] tail_ptr = '0;
    logic        busy;
    logic [31:0] cur_ptr;
    logic        stop_idle, stop_halt, frame_done;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic [31:0] m_tdata;
    logic [3:0]  m_tkeep;
    logic        m_tlast, m_tvalid;
    logic        m_tready = 1'b0;
    logic [31:0] c_tdata;
    logic        c_tlast, c_tvalid;
    logic        c_tready = 1'b0;

    always #2 clk = ~clk;

    sg_tx_engine i_sg_tx_engine (
        .clk(clk), .rst(rst), .run_en(run_en), .kick(kick),
        .head_ptr(head_ptr), .tail_ptr(tail_ptr), .busy(busy), .cur_ptr(cur_ptr),
        .stop_idle(stop_idle), .stop_halt(stop_halt), .frame_done(frame_done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .m_tdata(m_tdata), .m_tkeep(m_tkeep), .m_tlast(m_tlast), .m_tvalid(m_tvalid),
        .m_tready(m_tready),
        .c_tdata(c_tdata), .c_tlast(c_tlast), .c_tvalid(c_tvalid), .c_tready(c_tready)
    );

    logic [31:0] mem [0:1023];

    int n_chk = 0, n_bad = 0;
    int frame_cnt = 0, idle_cnt = 0, halt_cnt = 0;
    int ctl_got = 0, dat_seen = 0, req_cycles = 0;
    int stall = 0;
    int cyc = 0;

    logic [36:0] q_dat[$];
    int          q_need[$];
    logic [32:0] q_ctl[$];

    int  d_len[8];
    bit  d_sof[8], d_eof[8], d_cmp[8];

    bit          dat_hold_chk = 0, ctl_hold_chk = 0;
    logic [36:0] dat_prev;
    logic [32:0] ctl_prev;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_keep(input int len, input int b);
        int beats = (len + 3) / 4;
        if (b != beats - 1) return 4'hF;
        case (len % 4)
            1: return 4'h1;
            2: return 4'h3;
            3: return 4'h7;
            default: return 4'hF;
        endcase
    endfunction

    // Memory model, stream sinks and monitors, all on the falling edge.
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_req) req_cycles++;
            if (mem_ack) mem_ack = 1'b0;
            else if (mem_req && ($urandom % 3) != 0) begin
                mem_ack = 1'b1;
                if (mem_we) mem[mem_addr[11:2]] = mem_wdata;
                else        mem_rdata = mem[mem_addr[11:2]];
            end

            if (stop_idle)  idle_cnt++;
            if (stop_halt)  halt_cnt++;
            if (frame_done) frame_cnt++;

            // R9: stalled beats must persist unchanged
            if (dat_hold_chk)
                chk(m_tvalid && {m_tdata, m_tkeep, m_tlast} == dat_prev, "R9 data hold",
                    {m_tdata, m_tkeep, m_tlast}, dat_prev);
            if (ctl_hold_chk)
                chk(c_tvalid && {c_tdata, c_tlast} == ctl_prev, "R9 ctl hold",
                    {c_tdata, c_tlast}, ctl_prev);

            m_tready = (stall == 0) ? 1'b1 : (($urandom % 4) >= stall);
            c_tready = (stall == 0) ? 1'b1 : (($urandom % 4) >= stall);

            if (m_tvalid && m_tready) begin
                dat_seen++;
                if (q_dat.size() == 0) chk(0, "R6 unexpected data beat", {m_tdata, m_tkeep, m_tlast}, 0);
                else begin
                    logic [36:0] e;
                    int need;
                    e = q_dat.pop_front();
                    need = q_need.pop_front();
                    chk(m_tdata == e[36:5], "R6 data word", m_tdata, e[36:5]);
                    chk(m_tkeep == e[4:1], "R7 keep", m_tkeep, e[4:1]);
                    chk(m_tlast == e[0], "R8 last", m_tlast, e[0]);
                    chk(ctl_got == need, "R5 app words before data", ctl_got, need);
                end
            end
            if (c_tvalid && c_tready) begin
                ctl_got++;
                if (q_ctl.size() == 0) chk(0, "R5 unexpected ctl beat", {c_tdata, c_tlast}, 0);
                else begin
                    logic [32:0] e;
                    e = q_ctl.pop_front();
                    chk({c_tdata, c_tlast} == e, "R5 ctl word", {c_tdata, c_tlast}, e);
                end
            end
            dat_hold_chk = m_tvalid && !m_tready;
            dat_prev     = {m_tdata, m_tkeep, m_tlast};
            ctl_hold_chk = c_tvalid && !c_tready;
            ctl_prev     = {c_tdata, c_tlast};
        end
    end

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            finish_run();
        end
    end

    // Builds a chain of n descriptors, runs it and checks the outcome.
    task automatic run_chain(input int n, input int tail_i, input int stl);
        int ctl_tot = 0, exp_frames = 0, stop_at = 0, exp_beats = 0;
        bit is_halt = 0;
        logic [31:0] exp_cur = 0, saved = 0;
        int f0, i0, h0, s0, w;
        stall = stl;
        for (int i = 0; i < n; i++) begin
            int b = i * 16;
            mem[b + 0] = (i + 1) * 64;
            mem[b + 1] = $urandom;
            mem[b + 2] = 32'h400 + i * 64;
            mem[b + 3] = $urandom;
            mem[b + 4] = $urandom;
            mem[b + 6] = d_len[i] | ($urandom & 32'h7380_0000) |
                         (32'(d_eof[i]) << 26) | (32'(d_sof[i]) << 27);
            mem[b + 7] = d_cmp[i] ? (32'h8000_0000 | ($urandom & 32'hFFFF)) : ($urandom & 32'h7FFF_FFFF);
            for (int k = 0; k < 5; k++) mem[b + 8 + k] = $urandom;
            for (int k = 0; k < 16; k++) mem[256 + i * 16 + k] = $urandom;
        end
        for (int i = 0; i < n; i++) begin
            int b = i * 16;
            int beats = (d_len[i] + 3) / 4;
            stop_at = i;
            if (d_cmp[i]) begin
                is_halt = 1; exp_cur = i * 64; saved = mem[b + 7];
                break;
            end
            if (d_sof[i]) begin
                for (int k = 0; k < 5; k++) q_ctl.push_back({mem[b + 8 + k], k == 4});
                ctl_tot += 5;
            end
            for (int k = 0; k < beats; k++) begin
                q_dat.push_back({mem[256 + i * 16 + k], exp_keep(d_len[i], k),
                                 (k == beats - 1) && d_eof[i]});
                q_need.push_back(ctl_tot);
            end
            exp_beats += beats;
            if (d_eof[i]) exp_frames++;
            if (i == tail_i) begin
                exp_cur = mem[b + 0];
                break;
            end
        end
        ctl_got = 0;
        f0 = frame_cnt; i0 = idle_cnt; h0 = halt_cnt; s0 = dat_seen;
        @(negedge clk);
        head_ptr = 0; tail_ptr = tail_i * 64; kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
        w = 0;
        while (idle_cnt == i0 && halt_cnt == h0 && w < 20000) begin
            @(negedge clk); w++;
        end
        w = 0;
        while ((q_dat.size() != 0 || q_ctl.size() != 0 || m_tvalid || c_tvalid) && w < 2000) begin
            @(negedge clk); w++;
        end
        repeat (3) @(negedge clk);
        if (is_halt) chk(halt_cnt == h0 + 1 && idle_cnt == i0, "R4 halt stop", halt_cnt - h0, 1);
        else         chk(idle_cnt == i0 + 1 && halt_cnt == h0, "R11 idle stop", idle_cnt - i0, 1);
        chk(cur_ptr == exp_cur, "R11 cur_ptr", cur_ptr, exp_cur);
        chk(!busy, "R11 busy low", busy, 0);
        chk(frame_cnt - f0 == exp_frames, "R10 frame_done count", frame_cnt - f0, exp_frames);
        chk(dat_seen - s0 == exp_beats, "R12 beat count", dat_seen - s0, exp_beats);
        chk(q_dat.size() == 0 && q_ctl.size() == 0, "R6 all beats seen", q_dat.size() + q_ctl.size(), 0);
        for (int i = 0; i < stop_at + (is_halt ? 0 : 1); i++)
            chk(mem[i * 16 + 7] == 32'h8000_0000, "R10 status writeback", mem[i * 16 + 7], 32'h8000_0000);
        if (is_halt)
            chk(mem[stop_at * 16 + 7] == saved, "R4 status untouched", mem[stop_at * 16 + 7], saved);
        q_dat.delete(); q_need.delete(); q_ctl.delete();
    endtask

    task automatic set_desc(input int i, input int len, input bit sof, input bit eof, input bit cmp);
        d_len[i] = len; d_sof[i] = sof; d_eof[i] = eof; d_cmp[i] = cmp;
    endtask

    initial begin
        int r0;
        void'($urandom(32'h5EED_0001));
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !mem_req && !m_tvalid && !c_tvalid, "R1 reset outputs",
            {busy, mem_req, m_tvalid, c_tvalid}, 0);
        chk(!stop_idle && !stop_halt && !frame_done, "R1 reset pulses",
            {stop_idle, stop_halt, frame_done}, 0);

        // R2 kick without enable
        r0 = req_cycles;
        kick = 1'b1; tail_ptr = 0;
        @(negedge clk);
        kick = 1'b0;
        repeat (30) @(negedge clk);
        chk(!busy && req_cycles == r0 && dat_seen == 0 && ctl_got == 0, "R2 kick ignored",
            {busy, 8'(req_cycles - r0)}, 0);
        run_en = 1'b1;

        // R7 every tail-byte count, R3 masked control bits
        set_desc(0, 1, 1, 0, 0); set_desc(1, 2, 0, 0, 0); set_desc(2, 3, 0, 0, 0);
        set_desc(3, 4, 0, 0, 0); set_desc(4, 5, 0, 1, 0);
        run_chain(5, 4, 0);
        run_chain(5, 4, 3);

        // R12 zero-length descriptors with end-of-frame
        set_desc(0, 0, 1, 1, 0); set_desc(1, 8, 0, 0, 0); set_desc(2, 0, 0, 1, 0);
        run_chain(3, 2, 2);

        // R4 completed descriptor in the middle, then at the head
        set_desc(0, 13, 1, 0, 0); set_desc(1, 6, 0, 1, 0); set_desc(2, 9, 1, 1, 1);
        set_desc(3, 4, 0, 1, 0);
        run_chain(4, 3, 1);
        set_desc(0, 20, 1, 1, 1); set_desc(1, 4, 0, 1, 0);
        run_chain(2, 1, 0);

        // R11 tail is the first descriptor
        set_desc(0, 17, 1, 1, 0); set_desc(1, 4, 1, 1, 0); set_desc(2, 4, 1, 1, 0);
        run_chain(3, 0, 2);

        // Random chains
        for (int t = 0; t < 10; t++) begin
            int n = 1 + int'($urandom % 6);
            int ti = int'($urandom % n);
            for (int i = 0; i < n; i++)
                set_desc(i, int'($urandom % 45), $urandom % 2, $urandom % 2, ($urandom % 6) == 0);
            run_chain(n, ti, int'($urandom % 4));
        end
        finish_run();
    end

endmodule